// File: doc/BRIEF.md
# SYSREF Pulse Generator with Repeater

This block produces a low-rate SYSREF timing signal that is aligned to a fast input clock. In generator mode the input clock is first thinned by a selectable pre-divider (1, 2 or 4). A half-period counter then toggles the output, which gives an even overall ratio of `2*DIV+4` pre-divided ticks at a 50 % duty cycle. The waveform either runs freely for as long as the block is enabled, or comes out as a burst of a programmed number of pulses that a rising trigger edge starts.

In repeater mode the block does not generate anything. It forwards an externally supplied SYSREF instead, on one of two paths. The synchronous path retimes the input through a two-stage register chain that advances on the pre-divided tick. The raw path passes the input straight through with no register. A master enable forces the output low in every mode. All divider logic uses clock enables, so there are no derived clocks.

Top module: `sysref_pulse_gen`

## Requirements
- R1: While `cfg_enable` is 0 the output `sysref_out` is 0 in every mode, including the raw repeater path.
- R2: In generator mode with `cfg_burst_mode` = 0, `sysref_out` goes high at the first clock edge after the enable is seen. It then alternates high and low phases of `(cfg_div+2)*P` clock cycles each, where P is the pre-divide factor.
- R3: Pre-divider select `cfg_prediv_sel` gives P = 1 for code 0, P = 2 for code 1, and P = 4 for codes 2 and 3 (code 3 is reserved and behaves as code 2).
- R4: A divider code k gives a full output period of `(2k+4)*P` clock cycles: code 0 gives 4*P and code 7FFh gives 4098*P.
- R5: In generator mode with `cfg_burst_mode` = 1, the output stays low until a rising edge on `trig_in`. It then emits exactly `cfg_burst_len` pulses shaped as in R2, returns low, and a later rising edge starts a new burst.
- R6: A burst length of 0 is accepted, and a trigger edge then produces no pulse.
- R7: A rising edge of `trig_in` during a burst is ignored (the pulse count stays `cfg_burst_len`), and holding `trig_in` high does not restart a burst.
- R8: In repeater mode with `cfg_nosync` = 1, `sysref_out` equals `ext_sysref_in` in the same cycle, with no register in the path.
- R9: In repeater mode with `cfg_nosync` = 0, `ext_sysref_in` passes through two registers that advance on the pre-divided tick. With P = 1, `sysref_out` equals `ext_sysref_in` delayed by two clock cycles.
- R10: The source that is not selected has no effect: `ext_sysref_in` is ignored in generator mode, and `trig_in` is ignored in repeater mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all logic is synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Master enable for the whole block |
| cfg_mode_repeat | input | 1 | 0 = generate internally, 1 = repeat the external SYSREF |
| cfg_burst_mode | input | 1 | 0 = continuous output, 1 = triggered burst |
| cfg_nosync | input | 1 | Repeater path: 1 = raw pass-through, 0 = retimed |
| cfg_prediv_sel | input | 2 | Pre-divider code (0:/1, 1:/2, 2 and 3:/4) |
| cfg_div | input | 11 | Divider code k, ratio 2k+4 |
| cfg_burst_len | input | 4 | Pulses per burst, 0 to 15 |
| trig_in | input | 1 | Burst trigger, rising-edge sensitive |
| ext_sysref_in | input | 1 | External SYSREF for repeater mode |
| sysref_out | output | 1 | SYSREF output |

## Verification
Several properties are checked on every clock cycle by assertions:
- the output stays low while disabled;
- a generated high phase never lasts only one cycle;
- a burst never shows more rising edges than the programmed length;
- a zero-length burst stays quiet;
- with P = 1 the retimed repeater output matches the input from two cycles earlier.

Other behaviour can only be shown by the directed scenarios:
- the exact phase lengths for each pre-divider code and the divider extremes;
- the exact pulse count of a burst;
- rejection of a trigger edge that arrives in the middle of a burst;
- the same-cycle response of the raw path;
- the isolation of the source that is not selected.

// File: rtl/sysref_pkg.sv
package sysref_pkg;

    localparam int DIV_W_DEF  = 11;
    localparam int LEN_W_DEF  = 4;
    localparam int SYNC_DEPTH = 2;

    // which source currently feeds the output
    typedef enum logic [1:0] {
        SRC_OFF      = 2'd0,
        SRC_GEN      = 2'd1,
        SRC_RPT_SYNC = 2'd2,
        SRC_RPT_RAW  = 2'd3
    } src_e;

    // generator waveform state
    typedef struct packed {
        logic active;
        logic level;
    } wave_t;

    // terminal value of the pre-divide counter for a select code
    function automatic logic [1:0] prediv_last(input logic [1:0] sel);
        case (sel)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/sysref_prediv.sv
module sysref_prediv
    import sysref_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [1:0] cnt;
    logic [1:0] last;

    assign last = prediv_last(sel);
    assign tick = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 2'd1;
    end
endmodule

// File: rtl/sysref_burst_gen.sv
module sysref_burst_gen
    import sysref_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEF,
    parameter int LEN_W = LEN_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             burst_mode,
    input  logic             trig,
    input  logic             tick,
    input  logic [DIV_W-1:0] div,
    input  logic [LEN_W-1:0] burst_len,
    output logic             running,
    output logic             pulse
);
    localparam int HC_W = DIV_W + 1;

    wave_t            st;
    logic [HC_W-1:0]  hcnt;
    logic [HC_W-1:0]  half_last;
    logic [LEN_W-1:0] left;
    logic             trig_q;
    logic             start;
    logic             half_done;

    assign half_last = HC_W'(div) + HC_W'(1);
    assign half_done = tick && (hcnt == half_last);
    assign start     = !burst_mode || (trig && !trig_q && (burst_len != '0));

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            st   <= '0;
            hcnt <= '0;
            left <= '0;
        end else if (!st.active) begin
            if (start) begin
                st.active <= 1'b1;
                st.level  <= 1'b1;
                hcnt      <= '0;
                left      <= burst_len;
            end
        end else if (half_done) begin
            hcnt <= '0;
            if (st.level) begin
                st.level <= 1'b0;
            end else if (burst_mode && (left == LEN_W'(1))) begin
                st.active <= 1'b0;
            end else begin
                st.level <= 1'b1;
                if (burst_mode) left <= left - LEN_W'(1);
            end
        end else if (tick) begin
            hcnt <= hcnt + HC_W'(1);
        end
    end

    assign running = st.active;
    assign pulse   = st.level;
endmodule

// File: rtl/sysref_retime.sv
module sysref_retime
    import sysref_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst || clr)
                    chain[i] <= 1'b0;
                else if (tick)
                    chain[i] <= (i == 0) ? din : chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sysref_pulse_gen.sv
module sysref_pulse_gen
    import sysref_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEF,
    parameter int LEN_W = LEN_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enable,
    input  logic             cfg_mode_repeat,
    input  logic             cfg_burst_mode,
    input  logic             cfg_nosync,
    input  logic [1:0]       cfg_prediv_sel,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [LEN_W-1:0] cfg_burst_len,
    input  logic             trig_in,
    input  logic             ext_sysref_in,
    output logic             sysref_out
);
    src_e src;
    logic tick;
    logic prediv_run;
    logic gen_running;
    logic gen_pulse;
    logic rpt_sync;

    always_comb begin
        if (!cfg_enable)           src = SRC_OFF;
        else if (!cfg_mode_repeat) src = SRC_GEN;
        else if (cfg_nosync)       src = SRC_RPT_RAW;
        else                       src = SRC_RPT_SYNC;
    end

    assign prediv_run = (src == SRC_GEN) ? gen_running : (src == SRC_RPT_SYNC);

    sysref_prediv u_prediv (
        .clk  (clk),
        .rst  (rst),
        .run  (prediv_run),
        .sel  (cfg_prediv_sel),
        .tick (tick)
    );

    sysref_burst_gen #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_gen (
        .clk        (clk),
        .rst        (rst),
        .enable     (src == SRC_GEN),
        .burst_mode (cfg_burst_mode),
        .trig       (trig_in),
        .tick       (tick),
        .div        (cfg_div),
        .burst_len  (cfg_burst_len),
        .running    (gen_running),
        .pulse      (gen_pulse)
    );

    sysref_retime #(.STAGES(SYNC_DEPTH)) u_retime (
        .clk  (clk),
        .rst  (rst),
        .clr  (src != SRC_RPT_SYNC),
        .tick (tick),
        .din  (ext_sysref_in),
        .dout (rpt_sync)
    );

    always_comb begin
        case (src)
            SRC_GEN:      sysref_out = gen_pulse;
            SRC_RPT_SYNC: sysref_out = rpt_sync;
            SRC_RPT_RAW:  sysref_out = ext_sysref_in;
            default:      sysref_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/sysref_pulse_gen_chk.sv
module sysref_pulse_gen_chk #(
    parameter int DIV_W = 11,
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_enable,
    input logic             cfg_mode_repeat,
    input logic             cfg_burst_mode,
    input logic             cfg_nosync,
    input logic [1:0]       cfg_prediv_sel,
    input logic [DIV_W-1:0] cfg_div,
    input logic [LEN_W-1:0] cfg_burst_len,
    input logic             trig_in,
    input logic             ext_sysref_in,
    input logic             sysref_out
);
    logic           out_q;
    logic           trig_q;
    logic [LEN_W:0] rises;
    logic           burst_ctx;
    logic           sync_ctx;
    logic           zero_ctx;

    assign burst_ctx = cfg_enable && !cfg_mode_repeat && cfg_burst_mode;
    assign sync_ctx  = cfg_enable && cfg_mode_repeat && !cfg_nosync && (cfg_prediv_sel == 2'd0);
    assign zero_ctx  = burst_ctx && (cfg_burst_len == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= 1'b0;
            trig_q <= 1'b0;
            rises  <= '0;
        end else begin
            out_q  <= sysref_out;
            trig_q <= trig_in;
            if (!burst_ctx || (trig_in && !trig_q))
                rises <= '0;
            else if (sysref_out && !out_q)
                rises <= rises + 1'b1;
        end
    end

    // R1: disabled block drives nothing
    a_r1_off_low: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |-> !sysref_out);

    // R2: a generated high phase lasts at least two cycles
    a_r2_high_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable && !cfg_mode_repeat && $rose(sysref_out))
        |=> (!cfg_enable || cfg_mode_repeat || sysref_out));

    // R5: a burst never exceeds its programmed length
    a_r5_pulse_cap: assert property (@(posedge clk) disable iff (rst)
        burst_ctx |-> (rises <= {1'b0, cfg_burst_len}));

    // R6: zero-length burst stays low
    a_r6_zero_quiet: assert property (@(posedge clk) disable iff (rst)
        (zero_ctx && $past(zero_ctx) && !$past(sysref_out)) |-> !sysref_out);

    // R9: retimed repeater lags its input by two cycles at P = 1
    a_r9_sync_lag: assert property (@(posedge clk) disable iff (rst)
        (sync_ctx && $past(sync_ctx) && $past(sync_ctx, 2))
        |-> (sysref_out == $past(ext_sysref_in, 2)));
endmodule

bind sysref_pulse_gen sysref_pulse_gen_chk #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_enable      (cfg_enable),
    .cfg_mode_repeat (cfg_mode_repeat),
    .cfg_burst_mode  (cfg_burst_mode),
    .cfg_nosync      (cfg_nosync),
    .cfg_prediv_sel  (cfg_prediv_sel),
    .cfg_div         (cfg_div),
    .cfg_burst_len   (cfg_burst_len),
    .trig_in         (trig_in),
    .ext_sysref_in   (ext_sysref_in),
    .sysref_out      (sysref_out)
);

// File: tb/sysref_pulse_gen_tb.sv
module sysref_pulse_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        mode = 1'b0;
    logic        burst = 1'b0;
    logic        nosync = 1'b0;
    logic [1:0]  psel = 2'd0;
    logic [10:0] div = 11'd0;
    logic [3:0]  blen = 4'd0;
    logic        trig = 1'b0;
    logic        ext = 1'b0;
    logic        out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sysref_pulse_gen u_dut (
        .clk             (clk),
        .rst             (rst),
        .cfg_enable      (en),
        .cfg_mode_repeat (mode),
        .cfg_burst_mode  (burst),
        .cfg_nosync      (nosync),
        .cfg_prediv_sel  (psel),
        .cfg_div         (div),
        .cfg_burst_len   (blen),
        .trig_in         (trig),
        .ext_sysref_in   (ext),
        .sysref_out      (out)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pfac(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    task automatic go_idle();
        @(negedge clk);
        en = 0; mode = 0; burst = 0; nosync = 0; trig = 0; ext = 0;
        @(negedge clk);
    endtask

    // R2 R3 R4: continuous waveform phase lengths
    task automatic t_continuous(input logic [1:0] s, input logic [10:0] d, input string tag);
        int exp_half;
        int n;
        go_idle();
        psel = s; div = d;
        exp_half = (int'(d) + 2) * pfac(s);
        @(negedge clk); en = 1;
        @(posedge clk); #1;
        chk({tag, " R2 first edge high"}, int'(out), 1);
        n = 0;
        while (out === 1'b1 && n < 20000) begin n++; @(posedge clk); #1; end
        chk({tag, " high phase"}, n, exp_half);
        n = 0;
        while (out === 1'b0 && n < 20000) begin n++; @(posedge clk); #1; end
        chk({tag, " low phase"}, n, exp_half);
        chk({tag, " R4 next period high"}, int'(out), 1);
    endtask

    // R5 R6 R7 R10: triggered burst
    task automatic t_burst(input logic [3:0] len, input logic [1:0] s, input logic [10:0] d,
                           input bit mid, input string tag);
        int hp;
        int win;
        int rises;
        int mid_at;
        logic prev;
        go_idle();
        burst = 1; blen = len; psel = s; div = d;
        hp = (int'(d) + 2) * pfac(s);
        win = 2 * int'(len) * hp + 16;
        mid_at = 3 * hp;
        @(negedge clk); en = 1;
        rises = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); ext = k[0];
            @(posedge clk); #1;
            if (out) rises++;
        end
        ext = 0;
        chk({tag, " R5 R10 idle before trigger"}, rises, 0);
        prev = out;
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            trig = (k < 3) || (mid && k >= mid_at && k < mid_at + 3);
            @(posedge clk); #1;
            if (out && !prev) rises++;
            prev = out;
        end
        chk({tag, " pulse count"}, rises, int'(len));
        chk({tag, " R5 low after burst"}, int'(out), 0);
    endtask

    // R8 R10 R1: raw repeater
    task automatic t_rpt_raw();
        go_idle();
        mode = 1; nosync = 1; en = 1;
        @(negedge clk); ext = 1; #1;
        chk("R8 raw follows high", int'(out), 1);
        @(negedge clk); ext = 0; #1;
        chk("R8 raw follows low", int'(out), 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); trig = ~trig;
        end
        @(posedge clk); #1;
        chk("R10 trigger ignored in repeater", int'(out), 0);
        @(negedge clk); ext = 1; en = 0; #1;
        chk("R1 disabled raw path low", int'(out), 0);
    endtask

    // R9: retimed repeater latency
    task automatic t_rpt_sync();
        go_idle();
        mode = 1; nosync = 0; psel = 2'd0; en = 1;
        repeat (3) @(negedge clk);
        ext = 1;
        @(posedge clk); #1;
        chk("R9 not yet after one edge", int'(out), 0);
        @(posedge clk); #1;
        chk("R9 high after two edges", int'(out), 1);
        @(negedge clk); ext = 0;
        @(posedge clk); #1;
        chk("R9 still high after one edge", int'(out), 1);
        @(posedge clk); #1;
        chk("R9 low after two edges", int'(out), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk("R1 reset output low", int'(out), 0);
        rst = 0;
        @(negedge clk); #1;
        chk("R1 disabled after reset", int'(out), 0);

        t_continuous(2'd0, 11'd0,   "R3 R4 code0 p1");
        t_continuous(2'd1, 11'd0,   "R3 p2");
        t_continuous(2'd2, 11'd3,   "R3 p4");
        t_continuous(2'd3, 11'd1,   "R3 reserved p4");
        t_continuous(2'd0, 11'h7FF, "R4 max code");

        t_burst(4'd3,  2'd0, 11'd1, 1'b0, "R5 three");
        t_burst(4'd1,  2'd1, 11'd0, 1'b0, "R5 single");
        t_burst(4'd0,  2'd0, 11'd0, 1'b1, "R6 zero length");
        t_burst(4'd4,  2'd0, 11'd2, 1'b1, "R7 mid trigger");
        t_burst(4'd15, 2'd2, 11'd0, 1'b1, "R5 R7 fifteen");

        t_rpt_raw();
        t_rpt_sync();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule